// File: doc/BRIEF.md
# Disk Controller Interrupt Status Register Window

This block sits behind a 32-bit little-endian register bus and serves a 4 KiB window belonging to an IDE-style disk controller. Registers sit on a 16-byte stride, selected by address bits [11:4]. Inside the block every register is held big-endian: write data is byte-reversed on the way in and read data is byte-reversed on the way out. Because both directions are reversed, a value written to a plain storage register reads back unchanged on the bus.

Three indices are decoded:
- Index 0x20 is a side-effect-free timing word.
- Index 0x30 is an interrupt state word. Internal bit 31 is a sticky DMA-completion flag. It is set by a rising edge on the DMA interrupt input and cleared when software writes a one to it. Internal bit 30 is a live image of the disk interrupt level.
- Index 0 is a data port. It forwards the access to the drive side through a request/acknowledge handshake and reports completion only after the drive acknowledges.

Both raw interrupt inputs are also passed straight through to two interrupt outputs. Software uses the window to tune drive timing and to find out which interrupt source fired. It acknowledges a DMA completion by writing the flag bit.

Top module: `ide_irq_regwin`

## Requirements
- R1: A write to index 0x20 stores all 32 bits. A later read of index 0x20 returns the same bus value that was written.
- R2: After reset, index 0x20 reads 0 and index 0x30 reads 0, provided both interrupt inputs are low.
- R3: A rising edge on `dma_irq_in` sets internal bit 31 of index 0x30, which is bus bit 7 after byte reversal (bus value 0x00000080). The bit stays set after the input falls.
- R4: Writing bus value 0x00000080 (internal bit 31) to index 0x30 clears the DMA flag. A write to index 0x30 with that bit zero leaves the flag unchanged.
- R5: Internal bit 30 of index 0x30 (bus bit 6, value 0x00000040) reads as the level of `disk_irq_in` at the clock edge that captures the read.
- R6: When a DMA rising edge and a clearing write to index 0x30 fall on the same cycle, the flag ends up set.
- R7: Bits 29..0 of index 0x30 always read 0, and writes to them have no effect.
- R8: A read of any index other than 0, 0x20 and 0x30 returns 0xFFFFFFFF. A write to such an index changes no register.
- R9: `dma_irq_out` and `disk_irq_out` equal `dma_irq_in` and `disk_irq_in` in the same cycle.
- R10: An access to a register index (not 0) produces a single-cycle `bus_rsp` on the cycle after the request. Read data is valid on `bus_rdata` in that cycle.
- R11: A request to index 0 raises `drv_req` on the next cycle, with `drv_we` and the byte-reversed write data on `drv_wdata`. These stay stable until `drv_ack` is seen high. `drv_req` then drops and `bus_rsp` pulses. For a read, `bus_rdata` holds `drv_rdata` byte-reversed. `bus_busy` is high while the drive access is outstanding.
- R12: Address bits [3:0] are ignored in decoding; for example, 0x20C selects index 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle, only while `bus_busy` is low |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data, bus byte order |
| bus_busy | output | 1 | Data-port access outstanding |
| bus_rsp | output | 1 | Access-complete pulse |
| bus_rdata | output | 32 | Read data, bus byte order, valid with `bus_rsp` |
| drv_req | output | 1 | Drive data-port request |
| drv_we | output | 1 | Drive access direction |
| drv_wdata | output | 32 | Drive write data, internal byte order |
| drv_rdata | input | 32 | Drive read data, internal byte order |
| drv_ack | input | 1 | Drive acknowledge |
| dma_irq_in | input | 1 | Raw DMA completion interrupt |
| disk_irq_in | input | 1 | Raw disk interrupt level |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| disk_irq_out | output | 1 | Forwarded disk interrupt |

## Verification
Timing of results:
- Register reads and writes answer on the first clock edge after the request.
- Interrupt flag changes land on that same edge, so a read issued one cycle after the stimulus already observes them.
- The forwarded interrupt lines are combinational and can be checked in the same cycle as the input change.
- A data-port response follows the edge at which the acknowledge is sampled.

How the bench keeps to this: it drives every input on the falling clock edge and samples on the next falling edge. Each sample is therefore taken exactly one register stage after its stimulus. The bench also samples one cycle later to confirm that the response pulse has ended.

// File: rtl/ide_regwin_pkg.sv
// Package: shared constants for the disk controller register window.
// Assumes a 32-bit internal word; index values are decoded from addr[11:4].
package ide_regwin_pkg;
    localparam int IDX_W      = 8;
    localparam logic [IDX_W-1:0] IDX_DATA   = 8'h00;
    localparam logic [IDX_W-1:0] IDX_TIMING = 8'h20;
    localparam logic [IDX_W-1:0] IDX_IRQ    = 8'h30;
    localparam int DMA_BIT    = 31;
    localparam int DISK_BIT   = 30;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_TIMING = 2'd1,
        SEL_IRQ    = 2'd2,
        SEL_NONE   = 2'd3
    } regsel_e;
endpackage

// File: rtl/regwin_bswap.sv
// Module: reverses the byte order of a word.
// Assumes WIDTH is a whole number of bytes.
module regwin_bswap #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NBYTES = WIDTH / 8;

    // One byte lane per iteration, mirrored end to end.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
endmodule

// File: rtl/regwin_decode.sv
// Module: turns a byte address into a register selection.
// Assumes 32-bit accesses only; the bits below IDX_LSB are ignored.
module regwin_decode
    import ide_regwin_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);
    logic [ADDR_W-IDX_LSB-1:0] idx;
    logic                      unused_low;

    assign idx        = addr[ADDR_W-1:IDX_LSB];
    assign unused_low = ^addr[IDX_LSB-1:0];

    // Map the index onto one of the decoded registers.
    always_comb begin
        if (idx == IDX_W'(IDX_DATA))        sel = SEL_DATA;
        else if (idx == IDX_W'(IDX_TIMING)) sel = SEL_TIMING;
        else if (idx == IDX_W'(IDX_IRQ))    sel = SEL_IRQ;
        else                                sel = SEL_NONE;
    end
endmodule

// File: rtl/regwin_irqstat.sv
// Module: sticky DMA completion flag.
// It sets on a rising edge of the DMA input and clears on a software clear
// strobe. A set wins over a clear in the same cycle.
module regwin_irqstat (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_in,
    input  logic clr,
    output logic flag
);
    logic dma_prev;
    logic rise;

    assign rise = dma_in && !dma_prev;

    // Remember the last DMA level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_prev <= 1'b0;
        else        dma_prev <= dma_in;
    end

    // Update the sticky flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (rise) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R3
    dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_in && !dma_prev) |=> flag);
    // R4
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(dma_in && !dma_prev)) |=> !flag);
    // R3
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(dma_in && !dma_prev)) |=> $stable(flag));
endmodule

// File: rtl/regwin_dataport.sv
// Module: request/acknowledge handshake toward the drive data interface.
// Assumes a new start only arrives while busy is low.
module regwin_dataport #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic              req,
    output logic              req_we,
    output logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic              busy
);
    assign done = req && ack;
    assign busy = req;

    // Raise the request on start and hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)     req <= 1'b0;
        else if (start) req <= 1'b1;
        else if (done)  req <= 1'b0;
    end

    // Capture the direction and data of a new access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_wdata <= '0;
        end else if (start) begin
            req_we    <= we;
            req_wdata <= wdata;
        end
    end

    // R11
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_wdata) && $stable(req_we)));
    // R11
    dp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);
endmodule

// File: rtl/ide_irq_regwin.sv
// Module: top of the disk controller register window.
// Holds the timing word and the interrupt state word, forwards data-port
// accesses to the drive, and passes both interrupt lines straight through.
// Assumes the bus is little-endian and the registers are big-endian.
module ide_irq_regwin
    import ide_regwin_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int IDX_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_busy,
    output logic              bus_rsp,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              drv_req,
    output logic              drv_we,
    output logic [DATA_W-1:0] drv_wdata,
    input  logic [DATA_W-1:0] drv_rdata,
    input  logic              drv_ack,
    input  logic              dma_irq_in,
    input  logic              disk_irq_in,
    output logic              dma_irq_out,
    output logic              disk_irq_out
);
    localparam int UNUSED_W = DATA_W - 2;

    regsel_e           sel;
    logic [DATA_W-1:0] wdata_int;
    logic [DATA_W-1:0] timing_q;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] rd_int;
    logic [DATA_W-1:0] rd_bus;
    logic              accept;
    logic              reg_acc;
    logic              dp_start;
    logic              dp_done;
    logic              irq_clr;
    logic              dma_flag;
    logic              timing_wr;

    regwin_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    regwin_bswap #(.WIDTH(DATA_W)) u_wswap (
        .din  (bus_wdata),
        .dout (wdata_int)
    );

    assign accept    = bus_req && !bus_busy;
    assign reg_acc   = accept && (sel != SEL_DATA);
    assign dp_start  = accept && (sel == SEL_DATA);
    assign timing_wr = reg_acc && bus_we && (sel == SEL_TIMING);
    assign irq_clr   = reg_acc && bus_we && (sel == SEL_IRQ) && wdata_int[DMA_BIT];

    regwin_irqstat u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .dma_in (dma_irq_in),
        .clr    (irq_clr),
        .flag   (dma_flag)
    );

    regwin_dataport #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dp_start),
        .we        (bus_we),
        .wdata     (wdata_int),
        .ack       (drv_ack),
        .req       (drv_req),
        .req_we    (drv_we),
        .req_wdata (drv_wdata),
        .done      (dp_done),
        .busy      (bus_busy)
    );

    // Interrupt lines leave the block unchanged.
    assign dma_irq_out  = dma_irq_in;
    assign disk_irq_out = disk_irq_in;

    // Store the timing word on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)         timing_q <= '0;
        else if (timing_wr) timing_q <= wdata_int;
    end

    // Pick the internal value a register read returns.
    always_comb begin
        case (sel)
            SEL_TIMING: reg_rd = timing_q;
            SEL_IRQ:    reg_rd = {dma_flag, disk_irq_in, {UNUSED_W{1'b0}}};
            default:    reg_rd = '1;
        endcase
    end

    assign rd_int = dp_done ? drv_rdata : reg_rd;

    regwin_bswap #(.WIDTH(DATA_W)) u_rswap (
        .din  (rd_int),
        .dout (rd_bus)
    );

    // Register the response pulse and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rsp   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_rsp <= reg_acc || dp_done;
            if ((reg_acc && !bus_we) || (dp_done && !drv_we))
                bus_rdata <= rd_bus;
        end
    end

    // R10
    reg_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_acc |=> bus_rsp);
    // R1
    timing_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_wr |=> $stable(timing_q));
    // R11
    dp_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req && drv_ack) |=> bus_rsp);
    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp && !bus_busy && !drv_req) |=> !bus_rsp || $past(accept || dp_done));
endmodule

// File: tb/ide_irq_regwin_test.sv
module ide_irq_regwin_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_busy, bus_rsp;
    logic [31:0] bus_rdata;
    logic        drv_req, drv_we;
    logic [31:0] drv_wdata;
    logic [31:0] drv_rdata = '0;
    logic        drv_ack = 1'b0;
    logic        dma_irq_in = 1'b0, disk_irq_in = 1'b0;
    logic        dma_irq_out, disk_irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;
    logic        rv;

    always #2.5 clk = ~clk;

    ide_irq_regwin uut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_busy(bus_busy), .bus_rsp(bus_rsp), .bus_rdata(bus_rdata),
        .drv_req(drv_req), .drv_we(drv_we), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .drv_ack(drv_ack),
        .dma_irq_in(dma_irq_in), .disk_irq_in(disk_irq_in),
        .dma_irq_out(dma_irq_out), .disk_irq_out(disk_irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
        logic [3:0]  req;
    } vec_t;

    // Table walk with both interrupt inputs low.
    localparam int NVEC = 13;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 12'h200, 32'h0,        32'h0,        4'd2},  // R2
        '{1'b0, 12'h300, 32'h0,        32'h0,        4'd2},  // R2
        '{1'b1, 12'h200, 32'h11223344, 32'h0,        4'd1},
        '{1'b0, 12'h200, 32'h0,        32'h11223344, 4'd1},  // R1
        '{1'b0, 12'h20C, 32'h0,        32'h11223344, 4'd12}, // R12
        '{1'b0, 12'h100, 32'h0,        32'hFFFFFFFF, 4'd8},  // R8
        '{1'b1, 12'h100, 32'hDEADBEEF, 32'h0,        4'd8},
        '{1'b0, 12'h200, 32'h0,        32'h11223344, 4'd8},  // R8 no effect
        '{1'b1, 12'h300, 32'hFFFFFF7F, 32'h0,        4'd7},
        '{1'b0, 12'h300, 32'h0,        32'h0,        4'd7},  // R7
        '{1'b0, 12'hFF0, 32'h0,        32'hFFFFFFFF, 4'd8},  // R8
        '{1'b1, 12'h204, 32'hA5A55A5A, 32'h0,        4'd12},
        '{1'b0, 12'h200, 32'h0,        32'hA5A55A5A, 4'd1}   // R1, R12
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One register access; returns response flag and data one cycle later.
    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        rv = bus_rsp;
        rd = bus_rdata;
    endtask

    task automatic read_irq(input logic [31:0] exp, input string req);
        access(1'b0, 12'h300, 32'h0);
        check(rv && rd == exp, req, rd, exp);
    endtask

    initial begin
        #500000;
        errors++; checks++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state of outputs
        check(!bus_rsp && !drv_req && !bus_busy, "R2", {29'b0, bus_rsp, drv_req, bus_busy}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata);
            if (VECS[i].we)
                check(rv, $sformatf("R%0d", VECS[i].req), {31'b0, rv}, 32'h1);
            else
                check(rv && rd == VECS[i].rexp, $sformatf("R%0d", VECS[i].req), rd, VECS[i].rexp);
        end

        // R10 response pulse is one cycle wide
        access(1'b0, 12'h200, 32'h0);
        check(rv, "R10", {31'b0, rv}, 32'h1);
        @(negedge clk);
        check(!bus_rsp, "R10", {31'b0, bus_rsp}, 32'h0);

        // R3 rising edge sets flag (bus 0x80); R9 passthrough
        @(negedge clk);
        dma_irq_in = 1'b1;
        #1 check(dma_irq_out == 1'b1, "R9", {31'b0, dma_irq_out}, 32'h1);
        read_irq(32'h00000080, "R3");
        dma_irq_in = 1'b0;
        #1 check(dma_irq_out == 1'b0, "R9", {31'b0, dma_irq_out}, 32'h0);
        read_irq(32'h00000080, "R3");

        // R5 live disk level (bus 0x40)
        disk_irq_in = 1'b1;
        #1 check(disk_irq_out == 1'b1, "R9", {31'b0, disk_irq_out}, 32'h1);
        read_irq(32'h000000C0, "R5");
        disk_irq_in = 1'b0;
        read_irq(32'h00000080, "R5");

        // R4 write without bit 31 keeps flag, R7 other bits ignored
        access(1'b1, 12'h300, 32'hFFFFFF7F);
        read_irq(32'h00000080, "R4");
        // R4 clear
        access(1'b1, 12'h300, 32'h00000080);
        read_irq(32'h00000000, "R4");

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h300; bus_wdata = 32'h00000080;
        dma_irq_in = 1'b1;
        @(negedge clk);
        bus_req = 1'b0;
        read_irq(32'h00000080, "R6");
        // R3 level held high gives no new edge, so a clear sticks
        access(1'b1, 12'h300, 32'h00000080);
        read_irq(32'h00000000, "R3");
        dma_irq_in = 1'b0;

        // R11 data-port read
        access(1'b0, 12'h000, 32'h0);
        check(!rv && drv_req && !drv_we && bus_busy, "R11",
              {28'b0, rv, drv_req, drv_we, bus_busy}, 32'h5);
        repeat (2) @(negedge clk);
        check(drv_req && !bus_rsp, "R11", {30'b0, drv_req, bus_rsp}, 32'h2);
        drv_rdata = 32'hAABBCCDD; drv_ack = 1'b1;
        @(negedge clk);
        drv_ack = 1'b0;
        check(bus_rsp && !drv_req && bus_rdata == 32'hDDCCBBAA, "R11", bus_rdata, 32'hDDCCBBAA);
        @(negedge clk);
        check(!bus_rsp, "R11", {31'b0, bus_rsp}, 32'h0);

        // R11 data-port write, reversed data
        access(1'b1, 12'h008, 32'h01020304);
        check(drv_req && drv_we && drv_wdata == 32'h04030201, "R11", drv_wdata, 32'h04030201);
        drv_ack = 1'b1;
        @(negedge clk);
        drv_ack = 1'b0;
        check(bus_rsp && !drv_req, "R11", {30'b0, bus_rsp, drv_req}, 32'h2);

        // R2 reset mid-run clears timing word and flag
        dma_irq_in = 1'b1;
        access(1'b0, 12'h300, 32'h0);
        dma_irq_in = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 12'h200, 32'h0);
        check(rv && rd == 32'h0, "R2", rd, 32'h0);
        read_irq(32'h00000000, "R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule